// File: doc/BRIEF.md
# Time-of-Day Locked Pulse-Per-Second Generator

This block drives one timing output pin from a local time-of-day clock. The clock keeps a nanoseconds count that advances by a fixed step on every cycle, and a 48-bit seconds count that increments each time the nanoseconds count wraps. In its synchronized mode the pin gives one pulse per second. The pulse rises a programmable delay after the seconds value increments and stays high for a programmable width. Both values are in nanoseconds.

Software uses a small word-addressed register port to set the pin configuration word and the two waveform times, and to read the time of day. The configuration selects an action and can turn off the lock to the second boundary. With the action set to clock and the lock off, the pin runs as a free square wave whose low and high times come from the same two waveform registers. Any other action keeps the pin low.

Top module: `pps_tod_gen`

## Requirements
- R1: After reset the nanoseconds count is 0 and the seconds count is 0. On every clock the nanoseconds count grows by NS_STEP. When the sum reaches SEC_NS it wraps to the remainder, and in that same cycle the seconds count increments by one.
- R2: A read presented with rd_en returns its data on rd_data one clock later. rd_data then holds that value until the next read. The value is the state before that clock edge: offset 0x04 gives seconds bits [47:32] zero-extended, 0x08 gives seconds bits [31:0], 0x0C gives nanoseconds, and unmapped offsets read 0. Writes to 0x04, 0x08 and 0x0C are ignored.
- R3: The configuration word sits at offset 0x00 and resets to 0. Bit 0 is the domain select, bit 2 is the second-lock enable and bits [5:3] are the action. On read, all other bits are 0.
- R4: The pulse width register is at offset 0x14 and resets to 1000. The pulse delay register is at offset 0x18 and resets to 0. Both are 32 bits wide and read back what was written.
- R5: With an action other than 3 (0 = idle, and every other code), the pin stays low.
- R6: With action 3 and the lock on, the pulse rises in the first cycle of a second whose nanoseconds value is at least the delay. With the reset values this is the rollover cycle itself, at nanoseconds 0.
- R7: With action 3 and the lock on, the pin stays high while nanoseconds is below delay plus width. The width measured in cycles times NS_STEP therefore equals the programmed width.
- R8: With the lock on, new delay and width values apply only from the next seconds rollover. A pulse already under way keeps the values it started with.
- R9: With the lock on, a pin that is high in the last cycle of a second is low in the rollover cycle. This yields one pulse per second even when delay plus width reaches SEC_NS: such a pulse is cut at the boundary, and the next one rises no earlier than the second cycle of the new second.
- R10: With action 3 and the lock off, the pin enters the low phase when the mode is entered. It then alternates between max(1, ceil(delay/NS_STEP)) low cycles and max(1, ceil(width/NS_STEP)) high cycles, using the current register values, with no relation to the seconds boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte offset of the register to write |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Byte offset of the register to read |
| rd_data | output | DATA_W | Read data, valid the cycle after rd_en |
| pps_out | output | 1 | Timing pin output |

## Verification
A register write reaches the configuration and waveform registers at the next clock edge. Read data appears one edge after the strobe and reflects the time of day from before that edge, so the bench compares it against its own count of edges since reset, minus one. The pin register and the nanoseconds register update on the same edge. The bench therefore stamps each rising edge with the nanoseconds value modelled for that very cycle, and measures width and period in whole cycles times the step. Waveform changes in the locked mode are timed against the model clock, so that they land mid-second, and the bench queues expected pulses only for seconds after the next rollover (or for the pulse already in flight, which must keep its old shape).

// File: rtl/pps_pkg.sv
package pps_pkg;

  localparam int REG_AW = 5;

  // register byte offsets
  localparam logic [REG_AW-1:0] OFF_CFG     = 5'h00;
  localparam logic [REG_AW-1:0] OFF_SEC_HI  = 5'h04;
  localparam logic [REG_AW-1:0] OFF_SEC_LO  = 5'h08;
  localparam logic [REG_AW-1:0] OFF_NSEC    = 5'h0C;
  localparam logic [REG_AW-1:0] OFF_WIDTH   = 5'h14;
  localparam logic [REG_AW-1:0] OFF_DELAY   = 5'h18;

  // configuration word bit positions
  localparam int CFG_DOM_BIT = 0;
  localparam int CFG_LOCK_BIT = 2;
  localparam int CFG_ACT_LSB = 3;
  localparam int CFG_ACT_W = 3;

  localparam logic [CFG_ACT_W-1:0] ACT_IDLE  = 3'd0;
  localparam logic [CFG_ACT_W-1:0] ACT_CLOCK = 3'd3;

  typedef struct packed {
    logic [CFG_ACT_W-1:0] action;
    logic                 lock;
    logic                 domain;
  } pin_cfg_t;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;

endpackage

// File: rtl/pps_tod_counter.sv
module pps_tod_counter #(
  parameter int NS_STEP = 20,
  parameter int SEC_NS  = 1000000000,
  parameter int NS_W    = 30,
  parameter int SEC_W   = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [NS_W-1:0]  ns_q,
  output logic [NS_W-1:0]  ns_d,
  output logic [SEC_W-1:0] sec_q,
  output logic             tick_d,
  output logic             tick_q
);

  localparam int SUM_W = NS_W + 1;
  localparam logic [SUM_W-1:0] STEP_V = SUM_W'(NS_STEP);
  localparam logic [SUM_W-1:0] SEC_V  = SUM_W'(SEC_NS);

  logic [SUM_W-1:0] ns_sum;
  logic [SEC_W-1:0] sec_d;

  always_comb begin
    ns_sum = {1'b0, ns_q} + STEP_V;
    tick_d = (ns_sum >= SEC_V);
    if (tick_d) begin
      ns_d  = NS_W'(ns_sum - SEC_V);
      sec_d = sec_q + SEC_W'(1);
    end else begin
      ns_d  = NS_W'(ns_sum);
      sec_d = sec_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q   <= '0;
      sec_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      ns_q   <= ns_d;
      sec_q  <= sec_d;
      tick_q <= tick_d;
    end
  end

  // R1
  ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ns_q} < SEC_V);

  // R1
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q == $past(sec_q) + SEC_W'(tick_q));

  // R1
  tick_ns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> ({1'b0, ns_q} < STEP_V));

endmodule

// File: rtl/pps_pin_regs.sv
module pps_pin_regs
  import pps_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NS_W        = 30,
  parameter int SEC_W       = 48,
  parameter int DEF_HIGH_NS = 1000,
  parameter int DEF_LOW_NS  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  input  logic [SEC_W-1:0]  tod_sec,
  input  logic [NS_W-1:0]   tod_ns,
  output pin_cfg_t          cfg_q,
  output logic [DATA_W-1:0] width_q,
  output logic [DATA_W-1:0] delay_q,
  output logic [DATA_W-1:0] rd_data
);

  pin_cfg_t          cfg_d;
  logic [DATA_W-1:0] width_d, delay_d, rd_data_d, cfg_word;

  always_comb begin
    cfg_word = '0;
    cfg_word[CFG_DOM_BIT]  = cfg_q.domain;
    cfg_word[CFG_LOCK_BIT] = cfg_q.lock;
    cfg_word[CFG_ACT_LSB +: CFG_ACT_W] = cfg_q.action;
  end

  // write path
  always_comb begin
    cfg_d   = cfg_q;
    width_d = width_q;
    delay_d = delay_q;
    if (wr_en) begin
      case (wr_addr)
        OFF_CFG: begin
          cfg_d.domain = wr_data[CFG_DOM_BIT];
          cfg_d.lock   = wr_data[CFG_LOCK_BIT];
          cfg_d.action = wr_data[CFG_ACT_LSB +: CFG_ACT_W];
        end
        OFF_WIDTH: width_d = wr_data;
        OFF_DELAY: delay_d = wr_data;
        default: ;
      endcase
    end
  end

  // read path
  always_comb begin
    rd_data_d = rd_data;
    if (rd_en) begin
      case (rd_addr)
        OFF_CFG:    rd_data_d = cfg_word;
        OFF_SEC_HI: rd_data_d = DATA_W'(tod_sec >> DATA_W);
        OFF_SEC_LO: rd_data_d = DATA_W'(tod_sec);
        OFF_NSEC:   rd_data_d = DATA_W'(tod_ns);
        OFF_WIDTH:  rd_data_d = width_q;
        OFF_DELAY:  rd_data_d = delay_q;
        default:    rd_data_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      width_q <= DATA_W'(DEF_HIGH_NS);
      delay_q <= DATA_W'(DEF_LOW_NS);
      rd_data <= '0;
    end else begin
      cfg_q   <= cfg_d;
      width_q <= width_d;
      delay_q <= delay_d;
      rd_data <= rd_data_d;
    end
  end

  // R2
  ro_nsec_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == OFF_NSEC) |=> rd_data == DATA_W'($past(tod_ns)));

endmodule

// File: rtl/pps_wave_gen.sv
module pps_wave_gen
  import pps_pkg::*;
#(
  parameter int NS_STEP = 20,
  parameter int NS_W    = 30,
  parameter int WF_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CFG_ACT_W-1:0] action,
  input  logic                 lock,
  input  logic [WF_W-1:0]      width,
  input  logic [WF_W-1:0]      delay,
  input  logic [NS_W-1:0]      ns_q,
  input  logic [NS_W-1:0]      ns_d,
  input  logic                 tick_q,
  input  logic                 tick_d,
  output logic                 pin_q
);

  localparam int SUM_W = WF_W + 1;
  localparam logic [SUM_W-1:0] STEP_V = SUM_W'(NS_STEP);

  logic             clock_act, lock_mode, free_mode;
  logic [WF_W-1:0]  lat_delay_q, lat_delay_d, lat_width_q, lat_width_d;
  logic [SUM_W-1:0] win_start, win_end, ns_ext;
  logic             in_win, lock_pin;
  phase_e           phase_q, phase_d;
  logic [SUM_W-1:0] cnt_q, cnt_d, limit;
  logic             pin_d;

  always_comb begin
    clock_act = (action == ACT_CLOCK);
    lock_mode = clock_act & lock;
    free_mode = clock_act & ~lock;
  end

  // second-locked window: settings captured at rollover
  always_comb begin
    lat_delay_d = lat_delay_q;
    lat_width_d = lat_width_q;
    if (tick_d) begin
      lat_delay_d = delay;
      lat_width_d = width;
    end
    win_start = {1'b0, lat_delay_d};
    win_end   = {1'b0, lat_delay_d} + {1'b0, lat_width_d};
    ns_ext    = {{(SUM_W-NS_W){1'b0}}, ns_d};
    in_win    = (ns_ext >= win_start) && (ns_ext < win_end);
    lock_pin  = in_win && !(tick_d && pin_q);
  end

  // free-running square wave
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    limit   = (phase_q == PH_HIGH) ? {1'b0, width} : {1'b0, delay};
    if (!free_mode) begin
      phase_d = PH_LOW;
      cnt_d   = STEP_V;
    end else if (cnt_q >= limit) begin
      phase_d = (phase_q == PH_HIGH) ? PH_LOW : PH_HIGH;
      cnt_d   = STEP_V;
    end else begin
      cnt_d   = cnt_q + STEP_V;
    end
  end

  always_comb begin
    if (free_mode)      pin_d = (phase_d == PH_HIGH);
    else if (lock_mode) pin_d = lock_pin;
    else                pin_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_delay_q <= '0;
      lat_width_q <= '0;
      phase_q     <= PH_LOW;
      cnt_q       <= STEP_V;
      pin_q       <= 1'b0;
    end else begin
      lat_delay_q <= lat_delay_d;
      lat_width_q <= lat_width_d;
      phase_q     <= phase_d;
      cnt_q       <= cnt_d;
      pin_q       <= pin_d;
    end
  end

  // R5
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clock_act |=> !pin_q);

  // R9
  rollover_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock_mode) && tick_q && $past(pin_q)) |-> !pin_q);

  // R6
  rise_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock_mode) && $rose(pin_q)) |->
      ({{(SUM_W-NS_W){1'b0}}, ns_q} >= {1'b0, lat_delay_q}));

endmodule

// File: rtl/pps_tod_gen.sv
module pps_tod_gen
  import pps_pkg::*;
#(
  parameter int NS_STEP     = 20,
  parameter int SEC_NS      = 1000000000,
  parameter int SEC_W       = 48,
  parameter int DATA_W      = 32,
  parameter int DEF_HIGH_NS = 1000,
  parameter int DEF_LOW_NS  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              pps_out
);

  localparam int NS_W = $clog2(SEC_NS + NS_STEP);

  logic [NS_W-1:0]   ns_q, ns_d;
  logic [SEC_W-1:0]  sec_q;
  logic              tick_d, tick_q;
  pin_cfg_t          cfg_q;
  logic [DATA_W-1:0] width_q, delay_q;

  pps_tod_counter #(
    .NS_STEP(NS_STEP), .SEC_NS(SEC_NS), .NS_W(NS_W), .SEC_W(SEC_W)
  ) u_tod (
    .clk(clk), .rst_n(rst_n), .ns_q(ns_q), .ns_d(ns_d), .sec_q(sec_q),
    .tick_d(tick_d), .tick_q(tick_q)
  );

  pps_pin_regs #(
    .DATA_W(DATA_W), .NS_W(NS_W), .SEC_W(SEC_W),
    .DEF_HIGH_NS(DEF_HIGH_NS), .DEF_LOW_NS(DEF_LOW_NS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .tod_sec(sec_q), .tod_ns(ns_q), .cfg_q(cfg_q),
    .width_q(width_q), .delay_q(delay_q), .rd_data(rd_data)
  );

  pps_wave_gen #(
    .NS_STEP(NS_STEP), .NS_W(NS_W), .WF_W(DATA_W)
  ) u_wave (
    .clk(clk), .rst_n(rst_n), .action(cfg_q.action), .lock(cfg_q.lock),
    .width(width_q), .delay(delay_q), .ns_q(ns_q), .ns_d(ns_d),
    .tick_q(tick_q), .tick_d(tick_d), .pin_q(pps_out)
  );

endmodule

// File: tb/test_pps_tod_gen.sv
`timescale 1ns/1ps
module test_pps_tod_gen;
  localparam int STEP = 20;
  localparam int SEC  = 40000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [4:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        pps_out;

  always #10 clk = ~clk;

  pps_tod_gen #(.NS_STEP(STEP), .SEC_NS(SEC)) i_pps_tod_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .pps_out(pps_out)
  );

  // model time: clock edges since reset release
  longint edges;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) edges <= 0; else edges <= edges + 1;

  function automatic longint m_ns(longint e); return (e * STEP) % SEC; endfunction
  function automatic longint m_sec(longint e); return (e * STEP) / SEC; endfunction

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { int rise; int width; int period; string req; } exp_t;
  exp_t sb_q[$];
  exp_t it;

  task automatic push(int rise, int width, int period, string req);
    exp_t e;
    e.rise = rise; e.width = width; e.period = period; e.req = req;
    sb_q.push_back(e);
  endtask

  // monitor
  logic   prev_pin;
  longint rise_e, prev_rise_e;
  int     hi_cnt, rise_ns;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_pin = 1'b0; hi_cnt = 0; rise_e = -1; prev_rise_e = -1; rise_ns = 0;
    end else begin
      if (pps_out && !prev_pin) begin
        prev_rise_e = rise_e;
        rise_e = edges;
        rise_ns = int'(m_ns(edges));
        hi_cnt = 0;
      end
      if (pps_out) hi_cnt++;
      if (!pps_out && prev_pin && sb_q.size() > 0) begin
        it = sb_q.pop_front();
        if (it.rise >= 0) chk({it.req, " rise ns"}, rise_ns, it.rise);
        chk({it.req, " width ns"}, hi_cnt * STEP, it.width);
        if (it.period >= 0) chk({it.req, " period ns"}, (rise_e - prev_rise_e) * STEP, it.period);
      end
      prev_pin = pps_out;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, output longint e);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0;
    d = rd_data; e = edges - 1;
  endtask

  task automatic wait_ns(longint t);
    do @(negedge clk); while (m_ns(edges) != t);
  endtask

  task automatic wait_empty();
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    longint e;
    int hits;
    rst_n = 1'b0; wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    chk("R5 reset pin", pps_out, 0);
    chk("R2 reset rd_data", rd_data, 0);
    rst_n = 1'b1;

    // reset values of registers
    rd(5'h00, d, e); chk("R3 cfg reset", d, 0);
    rd(5'h14, d, e); chk("R4 width reset", d, 1000);
    rd(5'h18, d, e); chk("R4 delay reset", d, 0);
    // time of day reads, writes to read-only offsets ignored
    rd(5'h0C, d, e); chk("R1 nsec", d, m_ns(e));
    wr(5'h0C, 32'd12345); wr(5'h08, 32'd7);
    rd(5'h0C, d, e); chk("R2 nsec after ignored write", d, m_ns(e));
    rd(5'h10, d, e); chk("R2 unmapped", d, 0);
    wait_ns(SEC - 4 * STEP);
    wait_ns(100);
    rd(5'h08, d, e); chk("R1 sec lsb", d, m_sec(e));
    rd(5'h04, d, e); chk("R2 sec msb", d, 0);
    rd(5'h0C, d, e); chk("R2 nsec", d, m_ns(e));

    // enable second-locked clock action; reserved bits dropped
    wait_ns(20000);
    wr(5'h00, 32'h0000_00DD);
    rd(5'h00, d, e); chk("R3 cfg readback", d, 32'h1D);
    push(0, 1000, -1, "R6 default");
    push(0, 1000, -1, "R7 default");
    wait_empty();

    // new delay/width apply at next rollover
    wait_ns(20000);
    wr(5'h18, 32'd4000); wr(5'h14, 32'd2000);
    push(4000, 2000, -1, "R8 next second");
    wait_empty();

    // change during a pulse: current pulse keeps its shape
    wait_ns(5000);
    wr(5'h14, 32'd6000); wr(5'h18, 32'd8000);
    push(4000, 2000, -1, "R8 in-flight");
    push(8000, 6000, -1, "R7 new width");
    wait_empty();

    // window crossing the boundary is cut at rollover
    wait_ns(20000);
    wr(5'h14, 32'd3000); wr(5'h18, 32'd39000);
    push(39000, 1000, -1, "R9 cut");
    push(39000, 1000, -1, "R9 cut again");
    wait_empty();

    // width beyond a second with zero delay: forced low at rollover
    wait_ns(20000);
    wr(5'h18, 32'd0); wr(5'h14, 32'd50000);
    push(39000, 1000, -1, "R8 old shape");
    push(STEP, SEC - STEP, -1, "R9 forced low");
    push(STEP, SEC - STEP, -1, "R9 forced low again");
    wait_empty();

    // free-running square wave
    wr(5'h18, 32'd100); wr(5'h14, 32'd60);
    wr(5'h00, 32'h0000_0018);
    repeat (40) @(negedge clk);
    push(-1, 60, 160, "R10 free");
    push(-1, 60, 160, "R10 free");
    push(-1, 60, 160, "R10 free");
    wait_empty();
    wait_ns(SEC - 4 * STEP);
    push(-1, 60, 160, "R10 across rollover");
    push(-1, 60, 160, "R10 across rollover");
    push(-1, 60, 160, "R10 across rollover");
    wait_empty();

    // other action codes keep the pin low
    wr(5'h00, 32'h0000_002C);
    repeat (3) @(negedge clk);
    hits = 0;
    for (int i = 0; i < (SEC / STEP) + 100; i++) begin
      @(negedge clk); if (pps_out) hits++;
    end
    chk("R5 action 5 high cycles", hits, 0);
    wr(5'h00, 32'h0000_0004);
    repeat (3) @(negedge clk);
    hits = 0;
    for (int i = 0; i < (SEC / STEP) + 100; i++) begin
      @(negedge clk); if (pps_out) hits++;
    end
    chk("R5 idle high cycles", hits, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule